// File: doc/BRIEF.md
# Receive FIFO Read-Request Watermark

This block decides when the host should be asked to read from a MAC receive FIFO. It follows the bytes written into the FIFO for the frame now arriving and keeps the read request low until that frame has delivered a minimum length of 64 bytes. From that point the request follows the FIFO occupancy against a programmable threshold of 16, 32 or 64 bytes.

When a frame ends, the request is held high until the bytes that were in the FIFO at that moment have been read out. This makes sure the tail of the frame is always drained, whatever the threshold. A short (runt) frame gets the same end-of-frame drain, but only when runt acceptance is enabled; otherwise it never raises the request.

Burst mode keeps the assertion rule unchanged and only lowers the release point. A request that is already asserted stays high until 2 bytes or fewer remain, so the host can empty the FIFO down to its last word in one run. The FIFO storage, the frame parser and the occupancy counter all sit outside this block. The occupancy arrives on `fifo_level`.

Top module: `rx_rdreq_wmark`

## Requirements
- R1: While a frame is arriving (after `rx_sof`, before `rx_eof`) and fewer than 64 bytes of it have been written, `rd_req` stays low unless an earlier frame's drain hold is active.
- R2: On `rx_eof` for a frame of fewer than 64 bytes, a drain hold starts if `cfg_runt_ok` is 1. If `cfg_runt_ok` is 0, the frame raises no request.
- R3: Once the current frame has reached 64 bytes, `rd_req` is high whenever `fifo_level` is above the selected threshold.
- R4: With `cfg_burst` = 0, the drain hold inactive and `fifo_level` at or below the threshold, `rd_req` is low.
- R5: With `cfg_burst` = 1, an asserted request stays high while `fifo_level` is above 2 and drops once it is 2 or less. Assertion follows R3 unchanged.
- R6: On `rx_eof` of an eligible frame (64 bytes or more, or a runt under R2), the drain count loads with `fifo_level` minus that cycle's read. `rd_req` is high while the count is non-zero, whatever the threshold.
- R7: `cfg_thresh` encodes 0 = 16 bytes, 1 = 32 bytes, 2 = 64 bytes, 3 = 64 bytes.
- R8: While `rst_n` is low, `rd_req` is low and the frame count, frame state, drain count and hysteresis state are cleared.
- R9: Each `host_rd` strobe removes min(2, `fifo_level`) bytes, and the drain count decreases by min(2, count).
- R10: `rd_req` is combinational from the registered state and the current inputs. A write or read affects the request from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_wr | input | 1 | One byte of the current frame written into the FIFO this cycle |
| rx_sof | input | 1 | First cycle of a new frame (may coincide with its first `rx_wr`) |
| rx_eof | input | 1 | Frame complete; never coincides with `rx_wr` |
| host_rd | input | 1 | Host reads one word (up to 2 bytes) this cycle |
| fifo_level | input | LVL_W | Current FIFO occupancy in bytes |
| cfg_thresh | input | 2 | Threshold select, encoding per R7 |
| cfg_burst | input | 1 | Burst mode: release point lowered to 2 bytes |
| cfg_runt_ok | input | 1 | Accept runt frames |
| rd_req | output | 1 | Read request to the host |

Every port is a plain strobe or level. None has back-pressure: the FIFO and the host act on the strobes in the same cycle.

## Verification
Burst-mode release is the hardest case to reach. It needs a frame that has already passed 64 bytes and is still open, the request already high, and then reads that take the occupancy below the threshold without an end of frame, because an end of frame would start a drain hold and mask the release point. The stimulus writes 90 bytes with no end marker, reads the FIFO all the way to empty, then refills it before closing the frame. An odd-length runt checks the one-byte final read of the drain count.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [1:0] {
    THR_16  = 2'd0,
    THR_32  = 2'd1,
    THR_64  = 2'd2,
    THR_RSV = 2'd3
  } thr_sel_e;

  function automatic int unsigned thr_bytes(logic [1:0] code);
    case (thr_sel_e'(code))
      THR_16:  return 16;
      THR_32:  return 32;
      default: return 64;
    endcase
  endfunction
endpackage

// File: rtl/rxw_frame_track.sv
module rxw_frame_track #(
  parameter int MIN_LEN = 64,
  localparam int CNT_W = $clog2(MIN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_sof,
  input  logic rx_eof,
  input  logic rx_wr,
  output logic gate_open,
  output logic long_enough
);
  logic [CNT_W-1:0] cnt_q;
  logic             in_frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
    end else if (rx_sof) begin
      cnt_q      <= rx_wr ? CNT_W'(1) : '0;
      in_frame_q <= 1'b1;
    end else begin
      if (rx_eof) in_frame_q <= 1'b0;
      if (in_frame_q && rx_wr && (cnt_q < CNT_W'(MIN_LEN)))
        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign long_enough = (cnt_q >= CNT_W'(MIN_LEN));
  assign gate_open   = in_frame_q && long_enough;
endmodule

// File: rtl/rxw_drain.sv
module rxw_drain #(
  parameter int LVL_W      = 8,
  parameter int WORD_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             host_rd,
  input  logic [LVL_W-1:0] fifo_level,
  output logic [LVL_W-1:0] drain_cnt,
  output logic             draining
);
  localparam logic [LVL_W-1:0] WB = LVL_W'(WORD_BYTES);

  logic [LVL_W-1:0] lvl_take, cnt_take;

  always_comb begin
    lvl_take = '0;
    cnt_take = '0;
    if (host_rd) begin
      lvl_take = (fifo_level < WB) ? fifo_level : WB;
      cnt_take = (drain_cnt  < WB) ? drain_cnt  : WB;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    drain_cnt <= '0;
    else if (load) drain_cnt <= fifo_level - lvl_take;
    else           drain_cnt <= drain_cnt - cnt_take;
  end

  assign draining = (drain_cnt != '0);
endmodule

// File: rtl/rxw_req.sv
module rxw_req #(
  parameter int LVL_W       = 8,
  parameter int BURST_FLOOR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_open,
  input  logic             draining,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [1:0]       cfg_thresh,
  input  logic             cfg_burst,
  output logic             rd_req
);
  logic [LVL_W-1:0] thr_v, rel_v;
  logic             hold_q, above;

  assign thr_v = LVL_W'(rxw_pkg::thr_bytes(cfg_thresh));
  assign rel_v = cfg_burst ? LVL_W'(BURST_FLOOR) : thr_v;

  always_comb begin
    if (hold_q) above = (fifo_level > rel_v);
    else        above = (fifo_level > thr_v);
  end

  assign rd_req = draining || (gate_open && above);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= rd_req;
  end
endmodule

// File: rtl/rx_rdreq_wmark.sv
module rx_rdreq_wmark #(
  parameter int LVL_W       = 8,
  parameter int MIN_LEN     = 64,
  parameter int WORD_BYTES  = 2,
  parameter int BURST_FLOOR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_wr,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic             host_rd,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [1:0]       cfg_thresh,
  input  logic             cfg_burst,
  input  logic             cfg_runt_ok,
  output logic             rd_req
);
  logic             gate_open, long_enough, draining, drain_load;
  logic [LVL_W-1:0] drain_cnt;

  rxw_frame_track #(.MIN_LEN(MIN_LEN)) u_trk (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_wr(rx_wr),
    .gate_open(gate_open), .long_enough(long_enough)
  );

  assign drain_load = rx_eof && !rx_sof && (long_enough || cfg_runt_ok);

  rxw_drain #(.LVL_W(LVL_W), .WORD_BYTES(WORD_BYTES)) u_drn (
    .clk(clk), .rst_n(rst_n), .load(drain_load), .host_rd(host_rd),
    .fifo_level(fifo_level), .drain_cnt(drain_cnt), .draining(draining)
  );

  rxw_req #(.LVL_W(LVL_W), .BURST_FLOOR(BURST_FLOOR)) u_req (
    .clk(clk), .rst_n(rst_n), .gate_open(gate_open), .draining(draining),
    .fifo_level(fifo_level), .cfg_thresh(cfg_thresh), .cfg_burst(cfg_burst),
    .rd_req(rd_req)
  );
endmodule

// File: rtl/rx_rdreq_wmark_chk.sv
module rx_rdreq_wmark_chk #(
  parameter int LVL_W       = 8,
  parameter int BURST_FLOOR = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_eof,
  input logic             rx_sof,
  input logic             cfg_runt_ok,
  input logic             cfg_burst,
  input logic [1:0]       cfg_thresh,
  input logic [LVL_W-1:0] fifo_level,
  input logic [LVL_W-1:0] drain_cnt,
  input logic             gate_open,
  input logic             rd_req
);
  logic [LVL_W-1:0] thr_c;
  assign thr_c = LVL_W'(rxw_pkg::thr_bytes(cfg_thresh));

  // R1: a closed gate with no drain pending never raises the request
  p_gate_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && drain_cnt == '0) |-> !rd_req);

  // R2: an accepted runt end with bytes still present starts a drain hold
  p_runt_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eof && !rx_sof && cfg_runt_ok && fifo_level > LVL_W'(2)) |=> rd_req);

  // R4: in normal mode the request is low at or below the threshold
  p_norm_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_burst && drain_cnt == '0 && fifo_level <= thr_c) |-> !rd_req);

  // R5: nothing but a drain keeps the request up at the burst floor
  p_burst_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_cnt == '0 && fifo_level <= LVL_W'(BURST_FLOOR)) |-> !rd_req);

  // R6: a pending drain always requests
  p_drain_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_cnt != '0) |-> rd_req);

  // R8: reset keeps the request low
  always @(posedge clk) begin
    if (!rst_n) p_reset_low_r8: assert (!rd_req);
  end
endmodule

bind rx_rdreq_wmark rx_rdreq_wmark_chk #(.LVL_W(LVL_W), .BURST_FLOOR(BURST_FLOOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_eof(rx_eof), .rx_sof(rx_sof),
  .cfg_runt_ok(cfg_runt_ok), .cfg_burst(cfg_burst), .cfg_thresh(cfg_thresh),
  .fifo_level(fifo_level), .drain_cnt(drain_cnt), .gate_open(gate_open),
  .rd_req(rd_req)
);

// File: tb/sim_rx_rdreq_wmark.sv
module sim_rx_rdreq_wmark;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_wr = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, host_rd = 1'b0;
  logic [7:0] fifo_level = '0;
  logic [1:0] cfg_thresh = 2'd0;
  logic       cfg_burst = 1'b0, cfg_runt_ok = 1'b0;
  logic       rd_req;

  int n_chk = 0, n_err = 0;
  string tag = "R8";

  // behavioural reference state
  int  m_level = 0, m_cnt = 0, m_drain = 0;
  bit  m_in = 0, m_hold = 0;

  always #10 clk = ~clk;

  rx_rdreq_wmark u0 (
    .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .host_rd(host_rd), .fifo_level(fifo_level), .cfg_thresh(cfg_thresh),
    .cfg_burst(cfg_burst), .cfg_runt_ok(cfg_runt_ok), .rd_req(rd_req)
  );

  function automatic int thr_of(int code);   // R7
    if (code == 0) return 16;
    if (code == 1) return 32;
    return 64;
  endfunction

  function automatic bit model_req();
    int lim;
    if (!rst_n) return 0;                    // R8
    if (m_drain > 0) return 1;               // R6
    if (!(m_in && m_cnt >= 64)) return 0;    // R1
    lim = thr_of(cfg_thresh);
    if (m_hold && cfg_burst) lim = 2;        // R5
    return m_level > lim;                    // R3, R4
  endfunction

  task automatic step(bit w, bit r, bit s, bit e);
    bit exp;
    int take_l, take_d;
    @(negedge clk);
    rx_wr = w; host_rd = r; rx_sof = s; rx_eof = e;
    fifo_level = 8'(m_level);
    #2;
    exp = model_req();
    n_chk++;
    if (rd_req !== exp) begin
      n_err++;
      $display("FAIL %s: rd_req=%0b expected=%0b level=%0d", tag, rd_req, exp, m_level);
    end
    @(posedge clk);
    m_hold = exp;
    take_l = r ? ((m_level < 2) ? m_level : 2) : 0;
    take_d = r ? ((m_drain < 2) ? m_drain : 2) : 0;   // R9
    if (e && !s && (m_cnt >= 64 || cfg_runt_ok)) m_drain = m_level - take_l;
    else m_drain = m_drain - take_d;
    if (s) begin m_cnt = w ? 1 : 0; m_in = 1; end
    else begin
      if (e) m_in = 0;
      if (m_in && w && m_cnt < 64 && !e) m_cnt++;
    end
    m_level = m_level + (w ? 1 : 0) - take_l;
  endtask

  task automatic write_frame(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, i == 0, 1'b0);
  endtask

  task automatic read_until(int lvl);
    while (m_level > lvl) step(1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tag = "R8";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    // R1 then R3: threshold 16, request waits for the 64-byte gate
    cfg_thresh = 2'd0; tag = "R1";
    write_frame(63);
    tag = "R3";
    for (int i = 0; i < 37; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    tag = "R6";
    step(1'b0, 1'b0, 1'b0, 1'b1);
    read_until(0);

    // R4: threshold 32, drain down without frame end
    cfg_thresh = 2'd1; tag = "R4";
    write_frame(80);
    read_until(20);
    tag = "R6";
    step(1'b0, 1'b0, 1'b0, 1'b1);
    read_until(0);

    // R5: burst keeps requesting down to 2 bytes, refill re-asserts
    cfg_burst = 1'b1; cfg_thresh = 2'd2; tag = "R5";
    write_frame(90);
    read_until(0);
    for (int i = 0; i < 70; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    read_until(0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    cfg_burst = 1'b0;

    // R2 / R9: accepted odd-length runt, final read takes one byte
    cfg_runt_ok = 1'b1; cfg_thresh = 2'd0; tag = "R2";
    write_frame(41);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    tag = "R9";
    read_until(0);
    step(1'b0, 1'b0, 1'b0, 1'b0);

    // R2: rejected runt never requests
    cfg_runt_ok = 1'b0; tag = "R2";
    write_frame(30);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    read_until(0);

    // R7: reserved code behaves as 64
    cfg_thresh = 2'd3; tag = "R7";
    write_frame(100);
    read_until(50);
    cfg_thresh = 2'd1; tag = "R10";
    step(1'b0, 1'b0, 1'b0, 1'b0);
    read_until(20);
    tag = "R6";
    step(1'b0, 1'b1, 1'b0, 1'b1);
    read_until(0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule